// File: doc/BRIEF.md
# DMA Read-Side Client Multiplexer

This block lets one DMA engine serve several clients on the path where data is read out of client-side RAMs. Each client offers descriptors on its own port. A round-robin arbiter picks one client at a time and forwards its descriptor to the single engine descriptor port. On the way out, the block widens the descriptor tag with the index of the client that issued it. When the engine later reports status, the block uses those index bits to deliver the status to the right client, with the client's own tag restored.

The engine issues RAM read commands that carry a select field. The upper bits of that field name a client. The block removes those bits and hands the command only to the named client. Each issued command also pushes the client index into a small ordering FIFO. Read data is accepted only from the client at the head of that FIFO, so data reaches the engine in the order the commands were issued, even when several clients are busy at once.

No address map is involved. Routing depends only on the port a client is attached to. The engine, the client RAMs and the descriptor sources sit outside this block.

Top module: `dma_rd_client_mux`

## Requirements
- R1: A forwarded descriptor carries the granted client's address and length unchanged, and its engine tag is `{client_index, client_tag}`, with the client index in the upper IDX_W bits.
- R2: Descriptor arbitration is round-robin. Starting from the pointer, the first client in ascending cyclic order with a valid descriptor is granted. After a handshake with client g, the pointer moves to g+1 modulo N. After reset the pointer is 0.
- R3: Once a grant has been offered and the engine has not accepted it, the grant stays on the same client until the handshake. Only the granted client sees ready, and only when the engine is ready.
- R4: A status return raises the status valid of exactly one client, the one named by the upper IDX_W bits of the engine tag. The client tag output equals the lower CTAG_W bits of the engine tag.
- R5: A read command goes only to the client named by the upper IDX_W bits of the engine select. The client receives the lower RSEL_W select bits and the address unchanged.
- R6: The engine sees command ready only when the named client is ready and the ordering FIFO (ORD_DEPTH entries) is not full. When the FIFO is full, no client sees a command valid.
- R7: While commands are outstanding, read data is taken only from the client whose command is oldest. Only that client sees read ready, and data reaches the engine in command order.
- R8: With no command outstanding, the engine sees no read valid and no client sees read ready.
- R9: After reset, every valid output toward the engine and toward the clients is low, as long as the inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cl_desc_valid | input | N_CLIENTS | Per-client descriptor valid |
| cl_desc_ready | output | N_CLIENTS | Per-client descriptor ready |
| cl_desc_addr | input | N_CLIENTS*ADDR_W | Per-client descriptor address |
| cl_desc_len | input | N_CLIENTS*LEN_W | Per-client descriptor length |
| cl_desc_tag | input | N_CLIENTS*CTAG_W | Per-client descriptor tag |
| en_desc_valid | output | 1 | Engine descriptor valid |
| en_desc_ready | input | 1 | Engine descriptor ready |
| en_desc_addr | output | ADDR_W | Engine descriptor address |
| en_desc_len | output | LEN_W | Engine descriptor length |
| en_desc_tag | output | CTAG_W+IDX_W | Engine descriptor tag with client index |
| en_stat_valid | input | 1 | Engine status valid |
| en_stat_tag | input | CTAG_W+IDX_W | Engine status tag |
| cl_stat_valid | output | N_CLIENTS | Per-client status valid |
| cl_stat_tag | output | CTAG_W | Restored client tag |
| en_cmd_valid | input | 1 | Engine read command valid |
| en_cmd_ready | output | 1 | Engine read command ready |
| en_cmd_addr | input | ADDR_W | Engine read command address |
| en_cmd_sel | input | RSEL_W+IDX_W | Engine read select with client index |
| cl_cmd_valid | output | N_CLIENTS | Per-client read command valid |
| cl_cmd_ready | input | N_CLIENTS | Per-client read command ready |
| cl_cmd_addr | output | ADDR_W | Read address to clients |
| cl_cmd_sel | output | RSEL_W | Client-local read select |
| cl_rd_valid | input | N_CLIENTS | Per-client read data valid |
| cl_rd_ready | output | N_CLIENTS | Per-client read data ready |
| cl_rd_data | input | N_CLIENTS*DATA_W | Per-client read data |
| en_rd_valid | output | 1 | Read data valid to engine |
| en_rd_ready | input | 1 | Engine read data ready |
| en_rd_data | output | DATA_W | Read data to engine |

## Verification
Every routing output is combinational from the inputs and the registered state. The bench therefore drives each cycle's inputs just after the falling edge and compares outputs a few nanoseconds later, in the same cycle, before the rising edge. The arbiter pointer, the grant lock and the ordering FIFO change only at the rising edge, so the effect of a handshake first shows in the next cycle's sample. The bench updates its own pointer, lock and order queues right after that edge, ready for that sample.

// File: rtl/dmx_pkg.sv
`timescale 1ns/1ps
package dmx_pkg;
    // Width of a client index; at least one bit.
    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/dmx_rr_arb.sv
`timescale 1ns/1ps
// Round-robin grant over N requesters. An offered grant that is not
// acknowledged is locked until it is.
module dmx_rr_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          ack,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx,
    output logic [N-1:0]  gnt_onehot
);
    typedef struct packed {
        logic          lock;
        logic [IW-1:0] gidx;
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic          found;
    logic [IW-1:0] pick;
    int            j;

    always_comb begin
        found = 1'b0;
        pick  = st_q.ptr;
        j     = 0;
        for (int k = 0; k < N; k++) begin
            j = (int'(st_q.ptr) + k) % N;
            if (!found && req[j]) begin
                found = 1'b1;
                pick  = IW'(j);
            end
        end

        if (st_q.lock) begin
            gnt_idx   = st_q.gidx;
            gnt_valid = req[st_q.gidx];
        end else begin
            gnt_idx   = pick;
            gnt_valid = found;
        end

        st_d = st_q;
        if (gnt_valid && ack) begin
            st_d.lock = 1'b0;
            st_d.ptr  = (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
        end else if (gnt_valid) begin
            st_d.lock = 1'b1;
            st_d.gidx = gnt_idx;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_oh
        assign gnt_onehot[i] = gnt_valid && (gnt_idx == IW'(i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dmx_ord_fifo.sv
`timescale 1ns/1ps
// Small FIFO holding the client index of each issued read command.
module dmx_ord_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int PW   = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [PW:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp           = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + (PW+1)'(push) - (PW+1)'(pop);
    end

    assign dout  = st_q.mem[st_q.rp];
    assign full  = (st_q.cnt == (PW+1)'(DEPTH));
    assign empty = (st_q.cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dma_rd_client_mux.sv
`timescale 1ns/1ps
module dma_rd_client_mux #(
    parameter int N_CLIENTS = 4,
    parameter int CTAG_W    = 4,
    parameter int RSEL_W    = 2,
    parameter int ADDR_W    = 8,
    parameter int LEN_W     = 8,
    parameter int DATA_W    = 16,
    parameter int ORD_DEPTH = 4,
    localparam int IDX_W    = dmx_pkg::idx_bits(N_CLIENTS),
    localparam int ETAG_W   = CTAG_W + IDX_W,
    localparam int ESEL_W   = RSEL_W + IDX_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_CLIENTS-1:0]              cl_desc_valid,
    output logic [N_CLIENTS-1:0]              cl_desc_ready,
    input  logic [N_CLIENTS-1:0][ADDR_W-1:0]  cl_desc_addr,
    input  logic [N_CLIENTS-1:0][LEN_W-1:0]   cl_desc_len,
    input  logic [N_CLIENTS-1:0][CTAG_W-1:0]  cl_desc_tag,
    output logic                              en_desc_valid,
    input  logic                              en_desc_ready,
    output logic [ADDR_W-1:0]                 en_desc_addr,
    output logic [LEN_W-1:0]                  en_desc_len,
    output logic [ETAG_W-1:0]                 en_desc_tag,
    input  logic                              en_stat_valid,
    input  logic [ETAG_W-1:0]                 en_stat_tag,
    output logic [N_CLIENTS-1:0]              cl_stat_valid,
    output logic [CTAG_W-1:0]                 cl_stat_tag,
    input  logic                              en_cmd_valid,
    output logic                              en_cmd_ready,
    input  logic [ADDR_W-1:0]                 en_cmd_addr,
    input  logic [ESEL_W-1:0]                 en_cmd_sel,
    output logic [N_CLIENTS-1:0]              cl_cmd_valid,
    input  logic [N_CLIENTS-1:0]              cl_cmd_ready,
    output logic [ADDR_W-1:0]                 cl_cmd_addr,
    output logic [RSEL_W-1:0]                 cl_cmd_sel,
    input  logic [N_CLIENTS-1:0]              cl_rd_valid,
    output logic [N_CLIENTS-1:0]              cl_rd_ready,
    input  logic [N_CLIENTS-1:0][DATA_W-1:0]  cl_rd_data,
    output logic                              en_rd_valid,
    input  logic                              en_rd_ready,
    output logic [DATA_W-1:0]                 en_rd_data
);
    // ---------------- descriptor merge ----------------
    logic                 gnt_valid;
    logic [IDX_W-1:0]     gnt_idx;
    logic [N_CLIENTS-1:0] gnt_onehot;

    dmx_rr_arb #(.N(N_CLIENTS), .IW(IDX_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (cl_desc_valid),
        .ack        (en_desc_ready),
        .gnt_valid  (gnt_valid),
        .gnt_idx    (gnt_idx),
        .gnt_onehot (gnt_onehot)
    );

    assign en_desc_valid = gnt_valid;
    assign en_desc_addr  = cl_desc_addr[gnt_idx];
    assign en_desc_len   = cl_desc_len[gnt_idx];
    assign en_desc_tag   = {gnt_idx, cl_desc_tag[gnt_idx]};
    assign cl_desc_ready = gnt_onehot & {N_CLIENTS{en_desc_ready}};

    // ---------------- status return ----------------
    logic [IDX_W-1:0] stat_idx;
    assign stat_idx    = en_stat_tag[ETAG_W-1 -: IDX_W];
    assign cl_stat_tag = en_stat_tag[CTAG_W-1:0];

    for (genvar i = 0; i < N_CLIENTS; i++) begin : g_stat
        assign cl_stat_valid[i] = en_stat_valid && (stat_idx == IDX_W'(i));
    end

    // ---------------- read command steering ----------------
    logic [IDX_W-1:0]     cmd_idx;
    logic [N_CLIENTS-1:0] cmd_hit;
    logic                 ord_full;
    logic                 ord_empty;
    logic [IDX_W-1:0]     ord_head;
    logic                 cmd_push;
    logic                 rd_pop;

    assign cmd_idx     = en_cmd_sel[ESEL_W-1 -: IDX_W];
    assign cl_cmd_addr = en_cmd_addr;
    assign cl_cmd_sel  = en_cmd_sel[RSEL_W-1:0];

    for (genvar i = 0; i < N_CLIENTS; i++) begin : g_cmd
        assign cmd_hit[i]      = (cmd_idx == IDX_W'(i));
        assign cl_cmd_valid[i] = en_cmd_valid && !ord_full && cmd_hit[i];
    end

    assign en_cmd_ready = !ord_full && |(cmd_hit & cl_cmd_ready);
    assign cmd_push     = en_cmd_valid && en_cmd_ready;

    dmx_ord_fifo #(.DEPTH(ORD_DEPTH), .W(IDX_W)) u_ord (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmd_push),
        .din   (cmd_idx),
        .pop   (rd_pop),
        .dout  (ord_head),
        .full  (ord_full),
        .empty (ord_empty)
    );

    // ---------------- ordered read data merge ----------------
    for (genvar i = 0; i < N_CLIENTS; i++) begin : g_rd
        assign cl_rd_ready[i] = !ord_empty && en_rd_ready && (ord_head == IDX_W'(i));
    end

    assign en_rd_valid = !ord_empty && cl_rd_valid[ord_head];
    assign en_rd_data  = cl_rd_data[ord_head];
    assign rd_pop      = en_rd_valid && en_rd_ready;
endmodule

// File: rtl/dma_rd_client_mux_chk.sv
`timescale 1ns/1ps
module dma_rd_client_mux_chk #(
    parameter int N_CLIENTS = 4,
    parameter int ETAG_W    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en_desc_valid,
    input logic                 en_desc_ready,
    input logic [ETAG_W-1:0]    en_desc_tag,
    input logic [N_CLIENTS-1:0] cl_desc_ready,
    input logic [N_CLIENTS-1:0] cl_stat_valid,
    input logic [N_CLIENTS-1:0] cl_cmd_valid,
    input logic                 en_cmd_ready,
    input logic                 ord_full,
    input logic                 ord_empty,
    input logic                 en_rd_valid,
    input logic [N_CLIENTS-1:0] cl_rd_ready
);
    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_desc_valid && !en_desc_ready) |=> (en_desc_valid && $stable(en_desc_tag))); // R3
    AST_DESC_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cl_desc_ready)); // R3
    AST_STAT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cl_stat_valid)); // R4
    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cl_cmd_valid)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ord_full |-> (!en_cmd_ready && cl_cmd_valid == '0)); // R6
    AST_RD_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cl_rd_ready)); // R7
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ord_empty |-> (!en_rd_valid && cl_rd_ready == '0)); // R8
endmodule

bind dma_rd_client_mux dma_rd_client_mux_chk #(
    .N_CLIENTS (N_CLIENTS),
    .ETAG_W    (ETAG_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_desc_valid (en_desc_valid),
    .en_desc_ready (en_desc_ready),
    .en_desc_tag   (en_desc_tag),
    .cl_desc_ready (cl_desc_ready),
    .cl_stat_valid (cl_stat_valid),
    .cl_cmd_valid  (cl_cmd_valid),
    .en_cmd_ready  (en_cmd_ready),
    .ord_full      (ord_full),
    .ord_empty     (ord_empty),
    .en_rd_valid   (en_rd_valid),
    .cl_rd_ready   (cl_rd_ready)
);

// File: tb/dma_rd_client_mux_tb.sv
`timescale 1ns/1ps
module dma_rd_client_mux_tb;
    localparam int N  = 4;
    localparam int CT = 4;
    localparam int RS = 2;
    localparam int AW = 8;
    localparam int LW = 8;
    localparam int DW = 16;
    localparam int DEPTH = 4;
    localparam int IW = 2;
    localparam int ET = CT + IW;
    localparam int ES = RS + IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]          cl_desc_valid = '0;
    logic [N-1:0]          cl_desc_ready;
    logic [N-1:0][AW-1:0]  cl_desc_addr = '0;
    logic [N-1:0][LW-1:0]  cl_desc_len = '0;
    logic [N-1:0][CT-1:0]  cl_desc_tag = '0;
    logic                  en_desc_valid;
    logic                  en_desc_ready = 1'b0;
    logic [AW-1:0]         en_desc_addr;
    logic [LW-1:0]         en_desc_len;
    logic [ET-1:0]         en_desc_tag;
    logic                  en_stat_valid = 1'b0;
    logic [ET-1:0]         en_stat_tag = '0;
    logic [N-1:0]          cl_stat_valid;
    logic [CT-1:0]         cl_stat_tag;
    logic                  en_cmd_valid = 1'b0;
    logic                  en_cmd_ready;
    logic [AW-1:0]         en_cmd_addr = '0;
    logic [ES-1:0]         en_cmd_sel = '0;
    logic [N-1:0]          cl_cmd_valid;
    logic [N-1:0]          cl_cmd_ready = '0;
    logic [AW-1:0]         cl_cmd_addr;
    logic [RS-1:0]         cl_cmd_sel;
    logic [N-1:0]          cl_rd_valid = '0;
    logic [N-1:0]          cl_rd_ready;
    logic [N-1:0][DW-1:0]  cl_rd_data = '0;
    logic                  en_rd_valid;
    logic                  en_rd_ready = 1'b0;
    logic [DW-1:0]         en_rd_data;

    dma_rd_client_mux #(
        .N_CLIENTS(N), .CTAG_W(CT), .RSEL_W(RS), .ADDR_W(AW),
        .LEN_W(LW), .DATA_W(DW), .ORD_DEPTH(DEPTH)
    ) u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench reference state
    int ref_ptr = 0;
    bit ref_lock = 1'b0;
    int ref_gidx = 0;
    int ord_q[$];
    int exp_data_q[$];
    int cq[N][$];

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic bit pct(input int p);
        return ($urandom % 100) < p;
    endfunction

    function automatic int mk_data(input int idx, input logic [AW-1:0] a, input logic [RS-1:0] s);
        return int'({4'(idx), a, s, 2'b10});
    endfunction

    task automatic run(input int cycles, input int p_dv, input int p_dr, input int p_cv,
                       input int p_cr, input int p_rv, input int p_rr);
        for (int c = 0; c < cycles; c++) begin
            int g; bit v; int idx; bit full; bit exp_cr; int h; bit dhs; bit chs; bit rhs;
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                if (!cl_desc_valid[i] && pct(p_dv)) begin
                    cl_desc_valid[i] = 1'b1;
                    cl_desc_addr[i]  = AW'($urandom);
                    cl_desc_len[i]   = LW'($urandom);
                    cl_desc_tag[i]   = CT'($urandom);
                end
            end
            en_desc_ready = pct(p_dr);
            en_stat_valid = pct(50);
            en_stat_tag   = ET'($urandom);
            if (!en_cmd_valid && pct(p_cv)) begin
                en_cmd_valid = 1'b1;
                en_cmd_addr  = AW'($urandom);
                en_cmd_sel   = ES'($urandom);
            end
            for (int i = 0; i < N; i++) cl_cmd_ready[i] = pct(p_cr);
            for (int i = 0; i < N; i++) begin
                if (cq[i].size() > 0 && pct(p_rv)) begin
                    cl_rd_valid[i] = 1'b1;
                    cl_rd_data[i]  = DW'(cq[i][0]);
                end else begin
                    cl_rd_valid[i] = 1'b0;
                    cl_rd_data[i]  = DW'($urandom);
                end
            end
            en_rd_ready = pct(p_rr);
            #4;
            // descriptor side: R1 R2 R3
            v = 1'b0; g = ref_ptr;
            if (ref_lock) begin
                g = ref_gidx; v = cl_desc_valid[g];
            end else begin
                for (int k = 0; k < N; k++) begin
                    int j;
                    j = (ref_ptr + k) % N;
                    if (!v && cl_desc_valid[j]) begin v = 1'b1; g = j; end
                end
            end
            chk("R2 desc valid", 32'(en_desc_valid), 32'(v));
            if (v) begin
                chk("R1 desc tag", 32'(en_desc_tag), 32'({2'(g), cl_desc_tag[g]}));
                chk("R1 desc addr", 32'(en_desc_addr), 32'(cl_desc_addr[g]));
                chk("R1 desc len", 32'(en_desc_len), 32'(cl_desc_len[g]));
            end
            chk("R3 desc ready", 32'(cl_desc_ready), (v && en_desc_ready) ? (32'd1 << g) : 32'd0);
            // status: R4
            chk("R4 stat valid", 32'(cl_stat_valid),
                en_stat_valid ? (32'd1 << en_stat_tag[ET-1:CT]) : 32'd0);
            if (en_stat_valid) chk("R4 stat tag", 32'(cl_stat_tag), 32'(en_stat_tag[CT-1:0]));
            // commands: R5 R6
            idx = int'(en_cmd_sel[ES-1:RS]);
            full = (ord_q.size() >= DEPTH);
            chk("R5 cmd valid", 32'(cl_cmd_valid), (en_cmd_valid && !full) ? (32'd1 << idx) : 32'd0);
            if (en_cmd_valid) begin
                chk("R5 cmd sel", 32'(cl_cmd_sel), 32'(en_cmd_sel[RS-1:0]));
                chk("R5 cmd addr", 32'(cl_cmd_addr), 32'(en_cmd_addr));
            end
            exp_cr = !full && cl_cmd_ready[idx];
            chk("R6 cmd ready", 32'(en_cmd_ready), 32'(exp_cr));
            // read data: R7 R8
            h = 0;
            if (ord_q.size() == 0) begin
                chk("R8 rd valid", 32'(en_rd_valid), 32'd0);
                chk("R8 rd ready", 32'(cl_rd_ready), 32'd0);
            end else begin
                h = ord_q[0];
                chk("R7 rd valid", 32'(en_rd_valid), 32'(cl_rd_valid[h]));
                chk("R7 rd ready", 32'(cl_rd_ready), en_rd_ready ? (32'd1 << h) : 32'd0);
                if (cl_rd_valid[h]) chk("R7 rd data order", 32'(en_rd_data), 32'(exp_data_q[0]));
            end
            dhs = v && en_desc_ready;
            chs = en_cmd_valid && exp_cr;
            rhs = (ord_q.size() > 0) && cl_rd_valid[h] && en_rd_ready;
            @(posedge clk);
            #1;
            if (dhs) begin
                cl_desc_valid[g] = 1'b0;
                ref_ptr = (g + 1) % N;
                ref_lock = 1'b0;
            end else if (v) begin
                ref_lock = 1'b1;
                ref_gidx = g;
            end
            if (rhs) begin
                void'(ord_q.pop_front());
                void'(cq[h].pop_front());
                void'(exp_data_q.pop_front());
            end
            if (chs) begin
                int d;
                d = mk_data(idx, en_cmd_addr, en_cmd_sel[RS-1:0]);
                ord_q.push_back(idx);
                cq[idx].push_back(d);
                exp_data_q.push_back(d);
                en_cmd_valid = 1'b0;
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9: idle after reset
        chk("R9 desc valid", 32'(en_desc_valid), 32'd0);
        chk("R9 stat valid", 32'(cl_stat_valid), 32'd0);
        chk("R9 cmd valid", 32'(cl_cmd_valid), 32'd0);
        chk("R9 rd valid", 32'(en_rd_valid), 32'd0);
        chk("R9 rd ready", 32'(cl_rd_ready), 32'd0);
        // directed: all clients request, engine always ready -> strict rotation 0,1,2,3 (R2)
        run(40, 100, 100, 0, 0, 0, 0);
        // directed: engine rarely ready, grants must hold (R3)
        run(80, 70, 15, 0, 0, 0, 0);
        // directed: read data stalled, ordering FIFO fills, backpressure (R6)
        run(40, 0, 0, 100, 100, 100, 0);
        // drain the FIFO in order (R7, R8)
        run(40, 0, 0, 0, 100, 100, 100);
        // mixed random traffic on all interfaces
        run(600, 40, 60, 60, 70, 60, 70);
        run(300, 80, 40, 90, 50, 40, 40);
        // drain then confirm empty state (R8)
        run(60, 0, 100, 0, 100, 100, 100);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule